// File: doc/BRIEF.md
# Triggered Two-Channel Pair-Sum Decimator and Word Packer

This block sits behind a dual-channel ADC front end whose two channels are sampled on the same clock strobe. Each external trigger pulse opens a capture window of a programmed number of sample pairs. Within the window, the block halves the data rate. It does this by realigning each 16-bit sample, whose 12 significant bits are stored in the upper positions, to a signed 12-bit value. It then adds each consecutive pair of values on a channel, so no sample is thrown away.

The 16-bit sums from both channels are collected four at a time into a 64-bit word, which is offered on a valid/ready stream toward a streaming FIFO. A word that finds the output register still occupied is dropped and raises a sticky overflow flag. Triggers that arrive while a window is open are counted, not honoured. Capturing only part of each trigger period is done by programming a record shorter than the period, which lowers the duty cycle.

Top module: `acq_pair_packer`

## Requirements
- R1: A trigger event is a rising edge of `trig_in` (high in a cycle, low in the previous one). A trigger event seen while idle with a non-zero `rec_len` raises `busy` on the next clock. Samples presented while `busy` is low never produce output.
- R2: While `busy` is high, every cycle with `smp_valid` high captures one sample on each channel. `busy` falls after exactly `rec_len` captured cycles. `rec_len` is a multiple of 4. A trigger event with `rec_len` equal to 0 is ignored.
- R3: Each sample is realigned by an arithmetic right shift of 4 bits. Bits [3:0] of every sample have no effect on the output.
- R4: Within a record, captured samples 2k and 2k+1 of a channel are added. The 13-bit sum is sign-extended into a 16-bit result.
- R5: Both channels share one `smp_valid` strobe. Channel 0 is `smp_a` and channel 1 is `smp_b`.
- R6: An output word carries, from bits [15:0] upward: ch0 sum n, ch1 sum n, ch0 sum n+1, ch1 sum n+1. Words leave in record order.
- R7: `out_valid` stays high and `out_data` stays unchanged until a cycle with `out_ready` high.
- R8: A word that completes while `out_valid` is high and `out_ready` is low is discarded and sets `ovf_flag`. `ovf_flag` stays set until cleared, and setting wins over clearing.
- R9: A cycle with `ovf_clr` high and no overflow condition clears `ovf_flag` on the next clock.
- R10: A trigger event while `busy` is high leaves the current record unchanged and increments `miss_count`, which saturates at its maximum. An idle-time trigger event never changes `miss_count`.
- R11: After reset, `busy`, `out_valid` and `ovf_flag` are low and `miss_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_in | input | 1 | External trigger, rising edge starts a record |
| smp_valid | input | 1 | Both channel samples valid this cycle |
| smp_a | input | 16 | Channel 0 sample, MSB-justified 12 bits |
| smp_b | input | 16 | Channel 1 sample, MSB-justified 12 bits |
| rec_len | input | LEN_W | Samples per channel per record, multiple of 4 |
| ovf_clr | input | 1 | Clears the overflow flag |
| out_ready | input | 1 | Downstream accepts the word |
| out_valid | output | 1 | Packed word available |
| out_data | output | 64 | Packed word of four 16-bit sums |
| busy | output | 1 | Record capture in progress |
| ovf_flag | output | 1 | Sticky dropped-word flag |
| miss_count | output | MISS_W | Saturating count of triggers ignored while busy |

## Verification
A wrong pair phase or a wrong lane slot shows up in the first output word of a record, four captured samples after the trigger. It appears as sums of straddled samples or as swapped lanes. A record counter that is off by one shows at the end of the record, either as a missing or extra word or as `busy` held too long, and the next record then starts misaligned. Wrong overflow or miss bookkeeping appears on the flags within one cycle of the stalled word or of the ignored trigger.

// File: rtl/acq_pkg.sv
package acq_pkg;

    localparam int SMP_W  = 16;
    localparam int KEEP_W = 12;
    localparam int SUM_W  = KEEP_W + 1;
    localparam int CHANS  = 2;
    localparam int PAIRS  = 2;
    localparam int LANES  = CHANS * PAIRS;
    localparam int WORD_W = SMP_W * LANES;

    typedef logic [SMP_W-1:0]              smp_t;
    typedef logic [CHANS-1:0][SMP_W-1:0]   duo_t;
    typedef logic [LANES-1:0][SMP_W-1:0]   word_t;

    typedef enum logic {PH_FIRST, PH_SECOND} phase_e;

    // Keep the significant MSB-justified field as a signed value.
    function automatic logic signed [KEEP_W-1:0] realign(input smp_t s);
        return s[SMP_W-1 -: KEEP_W];
    endfunction

    // Add two realigned values and sign-extend into a full lane.
    function automatic smp_t widen_sum(input logic signed [KEEP_W-1:0] x,
                                       input logic signed [KEEP_W-1:0] y);
        logic [SUM_W-1:0] s;
        s = {x[KEEP_W-1], x} + {y[KEEP_W-1], y};
        return {{(SMP_W-SUM_W){s[SUM_W-1]}}, s};
    endfunction

endpackage

// File: rtl/acq_record_ctl.sv
module acq_record_ctl #(
    parameter int LEN_W  = 16,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              smp_valid,
    input  logic [LEN_W-1:0]  rec_len,
    output logic              busy,
    output logic              take,
    output logic              start,
    output logic [MISS_W-1:0] miss_count
);
    logic             trig_q;
    logic             trig_evt;
    logic [LEN_W-1:0] cnt;
    logic             last;

    assign trig_evt = trig_in & ~trig_q;
    assign take     = busy & smp_valid;
    assign last     = take && (cnt == LEN_W'(rec_len - 1'b1));
    assign start    = !busy && trig_evt && (rec_len != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q     <= 1'b0;
            busy       <= 1'b0;
            cnt        <= '0;
            miss_count <= '0;
        end else begin
            trig_q <= trig_in;
            if (!busy) begin
                cnt <= '0;
                if (start) busy <= 1'b1;
            end else begin
                if (take) begin
                    cnt <= cnt + 1'b1;
                    if (last) busy <= 1'b0;
                end
                if (trig_evt && (miss_count != '1))
                    miss_count <= miss_count + 1'b1;
            end
        end
    end
endmodule

// File: rtl/acq_pair_sum.sv
module acq_pair_sum
    import acq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic take,
    input  duo_t smp,
    output duo_t sum,
    output logic sum_valid
);
    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_FIRST;
            sum_valid <= 1'b0;
        end else begin
            sum_valid <= 1'b0;
            if (start) begin
                phase <= PH_FIRST;
            end else if (take) begin
                if (phase == PH_FIRST) begin
                    phase <= PH_SECOND;
                end else begin
                    phase     <= PH_FIRST;
                    sum_valid <= 1'b1;
                end
            end
        end
    end

    for (genvar c = 0; c < CHANS; c++) begin : g_chan
        logic signed [KEEP_W-1:0] held;
        always_ff @(posedge clk) begin
            if (rst) begin
                held   <= '0;
                sum[c] <= '0;
            end else if (take) begin
                if (phase == PH_FIRST) held   <= realign(smp[c]);
                else                   sum[c] <= widen_sum(held, realign(smp[c]));
            end
        end
    end
endmodule

// File: rtl/acq_word_pack.sv
module acq_word_pack
    import acq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  sum_valid,
    input  duo_t  sum,
    input  logic  out_ready,
    input  logic  ovf_clr,
    output word_t word_q,
    output logic  out_valid,
    output logic  ovf_flag
);
    localparam int SLOT_W = (PAIRS > 1) ? $clog2(PAIRS) : 1;

    logic [SLOT_W-1:0] slot;
    word_t             stage;
    word_t             next_stage;
    logic              slot_last;
    logic              slot_free;
    logic              drop;

    always_comb begin
        next_stage = stage;
        for (int c = 0; c < CHANS; c++)
            next_stage[CHANS*int'(slot) + c] = sum[c];
    end

    assign slot_last = (slot == SLOT_W'(PAIRS-1));
    assign slot_free = !out_valid || out_ready;
    assign drop      = sum_valid && slot_last && !slot_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '0;
            stage     <= '0;
            word_q    <= '0;
            out_valid <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            if (out_valid && out_ready) out_valid <= 1'b0;
            if (start) begin
                slot <= '0;
            end else if (sum_valid) begin
                stage <= next_stage;
                slot  <= slot_last ? '0 : slot + 1'b1;
                if (slot_last && slot_free) begin
                    word_q    <= next_stage;
                    out_valid <= 1'b1;
                end
            end
            if (drop)         ovf_flag <= 1'b1;
            else if (ovf_clr) ovf_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/acq_pair_packer.sv
module acq_pair_packer
    import acq_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig_in,
    input  logic              smp_valid,
    input  logic [15:0]       smp_a,
    input  logic [15:0]       smp_b,
    input  logic [LEN_W-1:0]  rec_len,
    input  logic              ovf_clr,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [63:0]       out_data,
    output logic              busy,
    output logic              ovf_flag,
    output logic [MISS_W-1:0] miss_count
);
    logic  take;
    logic  start;
    duo_t  smp;
    duo_t  sum;
    logic  sum_valid;
    word_t word_q;

    assign smp      = {smp_b, smp_a};
    assign out_data = word_q;

    acq_record_ctl #(.LEN_W(LEN_W), .MISS_W(MISS_W)) i_ctl (
        .clk(clk), .rst(rst), .trig_in(trig_in), .smp_valid(smp_valid),
        .rec_len(rec_len), .busy(busy), .take(take), .start(start),
        .miss_count(miss_count)
    );

    acq_pair_sum i_sum (
        .clk(clk), .rst(rst), .start(start), .take(take), .smp(smp),
        .sum(sum), .sum_valid(sum_valid)
    );

    acq_word_pack i_pack (
        .clk(clk), .rst(rst), .start(start), .sum_valid(sum_valid), .sum(sum),
        .out_ready(out_ready), .ovf_clr(ovf_clr), .word_q(word_q),
        .out_valid(out_valid), .ovf_flag(ovf_flag)
    );
endmodule

// File: rtl/acq_pair_packer_chk.sv
module acq_pair_packer_chk #(
    parameter int LEN_W  = 16,
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              smp_valid,
    input logic [LEN_W-1:0]  rec_len,
    input logic              ovf_clr,
    input logic              out_ready,
    input logic              out_valid,
    input logic [63:0]       out_data,
    input logic              busy,
    input logic              ovf_flag,
    input logic [MISS_W-1:0] miss_count
);
    logic [LEN_W:0] seen;

    always_ff @(posedge clk) begin
        if (rst || !busy) seen <= '0;
        else if (smp_valid) seen <= seen + 1'b1;
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R7
    AST_MISS_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(miss_count)); // R10
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(out_valid) && !$past(out_ready)); // R8
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_flag && !ovf_clr |=> ovf_flag); // R8
    AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        ovf_clr && !(out_valid && !out_ready) |=> !ovf_flag); // R9
    AST_REC_LEN: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> seen == {1'b0, rec_len}); // R2
    AST_BUSY_END: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(smp_valid)); // R2
endmodule

bind acq_pair_packer acq_pair_packer_chk #(.LEN_W(LEN_W), .MISS_W(MISS_W)) i_chk (.*);

// File: tb/test_acq_pair_packer.sv
module test_acq_pair_packer;
    localparam int LEN_W  = 16;
    localparam int MISS_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trig_in = 1'b0, smp_valid = 1'b0, ovf_clr = 1'b0, out_ready = 1'b1;
    logic [15:0] smp_a = '0, smp_b = '0;
    logic [LEN_W-1:0] rec_len = '0;
    logic out_valid, busy, ovf_flag;
    logic [63:0] out_data;
    logic [MISS_W-1:0] miss_count;

    always #2 clk = ~clk;

    acq_pair_packer #(.LEN_W(LEN_W), .MISS_W(MISS_W)) i_acq_pair_packer (.*);

    logic [15:0] sa [0:4095];
    logic [15:0] sb [0:4095];
    logic [63:0] exp_w [0:1023];
    logic [63:0] got_w [0:2047];
    int got_n = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always @(negedge clk)
        if (!rst && out_valid && out_ready && got_n < 2048) begin
            got_w[got_n] = out_data;
            got_n++;
        end

    function automatic logic [15:0] psum(input logic [15:0] x, input logic [15:0] y);
        int t;
        t = int'($signed(x) >>> 4) + int'($signed(y) >>> 4);
        return t[15:0];
    endfunction

    task automatic build_exp(input int n);
        for (int w = 0; w < n/4; w++)
            exp_w[w] = {psum(sb[4*w+2], sb[4*w+3]), psum(sa[4*w+2], sa[4*w+3]),
                        psum(sb[4*w], sb[4*w+1]), psum(sa[4*w], sa[4*w+1])};
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Trigger, then send n samples; gap inserts idle cycles; miss_at re-pulses trigger.
    task automatic run_record(input int n, input bit gap, input int miss_at);
        got_n = 0;
        trig_in = 1'b1;
        tick(1);
        trig_in = 1'b0;
        for (int i = 0; i < n; i++) begin
            trig_in = (i == miss_at);
            smp_a = sa[i]; smp_b = sb[i]; smp_valid = 1'b1;
            tick(1);
            if (gap) begin
                smp_valid = 1'b0; trig_in = 1'b0;
                tick(1);
            end
        end
        trig_in = 1'b0; smp_valid = 1'b0;
        tick(6);
    endtask

    task automatic compare_words(input string req, input int n);
        chk({req, " word count"}, 64'(got_n), 64'(n/4));
        for (int w = 0; w < n/4; w++) chk(req, got_w[w], exp_w[w]);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        tick(5);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 busy", 64'(busy), 0);
        chk("R11 out_valid", 64'(out_valid), 0);
        chk("R11 ovf_flag", 64'(ovf_flag), 0);
        chk("R11 miss_count", 64'(miss_count), 0);
        tick(1);

        // R1: samples without a trigger are ignored
        got_n = 0;
        for (int i = 0; i < 8; i++) begin
            smp_a = 16'h1230 + 16'(i); smp_b = 16'h4560; smp_valid = 1'b1;
            tick(1);
        end
        smp_valid = 1'b0;
        tick(6);
        chk("R1 no output untriggered", 64'(got_n), 0);
        chk("R1 busy idle", 64'(busy), 0);

        // R2: zero length trigger ignored
        rec_len = '0;
        trig_in = 1'b1; tick(1); trig_in = 1'b0; tick(1);
        chk("R2 zero length no start", 64'(busy), 0);

        // R3 R4 R5 R6: extremes, low-nibble junk, lane order
        rec_len = 16'd8;
        sa[0] = 16'h7FF0; sa[1] = 16'h7FFF; sa[2] = 16'h8000; sa[3] = 16'h800F;
        sa[4] = 16'h0010; sa[5] = 16'hFFF0; sa[6] = 16'h1234; sa[7] = 16'h0005;
        sb[0] = 16'h0019; sb[1] = 16'h002A; sb[2] = 16'hFFFF; sb[3] = 16'hFFF3;
        sb[4] = 16'h4000; sb[5] = 16'hC00C; sb[6] = 16'h7FF7; sb[7] = 16'h8001;
        build_exp(8);
        chk("R4 max pair", 64'(exp_w[0][15:0]), 64'h0FFE);
        chk("R4 min pair", 64'(exp_w[0][47:32]), 64'hF000);
        run_record(8, 0, -1);
        compare_words("R6 R3 R4 extremes", 8);
        chk("R2 busy after record", 64'(busy), 0);

        // R3 R4: sweep over every 12-bit code on both channels
        rec_len = 16'd4096;
        for (int i = 0; i < 4096; i++) begin
            sa[i] = {12'(i), 4'(i) ^ 4'hA};
            sb[i] = {~12'(i), 4'(i >> 4)};
        end
        build_exp(4096);
        run_record(4096, 0, -1);
        compare_words("R4 R5 sweep", 4096);

        // R2 R10: gapped strobe, trigger during the record is counted
        rec_len = 16'd16;
        for (int i = 0; i < 16; i++) begin
            sa[i] = 16'(i * 16'h0911);
            sb[i] = 16'(16'hF000 - i * 16'h0130);
        end
        build_exp(16);
        run_record(16, 1, 5);
        compare_words("R10 R2 gapped record", 16);
        chk("R10 miss count", 64'(miss_count), 1);
        chk("R2 busy after gapped", 64'(busy), 0);

        // R2: samples after the record end are ignored
        got_n = 0;
        for (int i = 0; i < 4; i++) begin
            smp_valid = 1'b1; tick(1);
        end
        smp_valid = 1'b0;
        tick(6);
        chk("R2 no output after end", 64'(got_n), 0);

        // R7 R8 R9: stalled output
        rec_len = 16'd8;
        build_exp(8);
        out_ready = 1'b0;
        run_record(8, 0, -1);
        chk("R7 word held", 64'(out_valid), 1);
        chk("R7 held data", out_data, exp_w[0]);
        chk("R8 overflow set", 64'(ovf_flag), 1);
        out_ready = 1'b1;
        tick(4);
        chk("R8 second word dropped", 64'(got_n), 1);
        chk("R8 first word intact", got_w[0], exp_w[0]);
        chk("R8 flag sticky", 64'(ovf_flag), 1);
        chk("R10 idle trigger not counted", 64'(miss_count), 1);
        ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
        @(negedge clk);
        chk("R9 flag cleared", 64'(ovf_flag), 0);

        tick(2);
        finish_run();
    end
endmodule